// File: doc/BRIEF.md
# Daisy-Chained Interrupt Acknowledge

This block joins a row of identical slot cells to a small arbiter on the processor side. It carries interrupts from many requesters to one processor over a single shared request line, and it sends back one acknowledge that travels down the row. Each slot has a local request input and a local vector word. All requesting slots drive the shared line together as a wired OR, so the line stays high while any of them needs service. When the processor is ready, the arbiter raises the acknowledge for a fixed window. The acknowledge enters slot 0 first, so slot 0 sits nearest the processor.

A slot that is not requesting passes the acknowledge on to the next slot. A slot that is requesting when the acknowledge reaches it keeps it, is granted, and places its vector on the shared vector bus. Priority therefore comes from position in the row, and the priority decision is spread across the slots instead of sitting in one central encoder. Each slot records its decision at the rising edge of the acknowledge, so a request that changes partway through the window cannot split the grant. After a grant, the arbiter issues no further acknowledge until the serviced slot's handler has dropped that slot's request. If the acknowledge runs off the end of the row without a taker, the arbiter sets a spurious-acknowledge flag.

Top module: `irq_daisy_chain`

## Requirements
- R1: `irq_o` is the combinational OR of all bits of `req_i`. A second request while the line is already high changes nothing on it.
- R2: When the arbiter is idle and a cycle shows `irq_o` and `cpu_ready_i` both high, `ack_o` goes high on the next cycle. It then stays high for exactly ACK_WIN cycles (4 by default).
- R3: During an acknowledge, the grant goes to the lowest-numbered slot whose request was high in the first cycle of the window. Slot 0 has the highest priority. `grant_o[i]` is the grant of slot i.
- R4: At most one bit of `grant_o` is high at any time. The granted slot stays the same for the whole window, even if requests rise or fall after the first cycle of the window.
- R5: While a slot is granted, `vec_o` equals that slot's vector, taken from `slot_vec_i[i*VEC_W +: VEC_W]`, and `vec_valid_o` is high. Otherwise `vec_o` is zero and `vec_valid_o` is low.
- R6: After a window that granted a slot, `ack_o` stays low until that slot's request has been low on a clock edge and the arbiter has seen the slot leave service on the following edge. Only then can the next requester be acknowledged.
- R7: If no slot took the acknowledge, `spurious_o` goes high on the cycle after the window ends. It stays high until the next acknowledge window begins and is cleared on its first cycle. A window with a taker leaves `spurious_o` low.
- R8: During reset, `ack_o`, `grant_o`, `vec_o`, `vec_valid_o` and `spurious_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_ready_i | input | 1 | Processor can accept an interrupt |
| req_i | input | SLOTS | Level-sensitive request of each slot |
| slot_vec_i | input | SLOTS*VEC_W | Vector word of each slot, slot i at bits i*VEC_W upward |
| irq_o | output | 1 | Shared wired-OR request line |
| ack_o | output | 1 | Acknowledge driven into slot 0 |
| grant_o | output | SLOTS | Granted slot, one-hot or zero |
| vec_o | output | VEC_W | Shared vector bus |
| vec_valid_o | output | 1 | Vector bus carries a granted vector |
| spurious_o | output | 1 | Last acknowledge found no taker |

## Verification
A slot that records its decision at the wrong moment shows up at the ports within the same window. The grant moves to another slot partway through, or two grant bits rise together, and the vector bus changes without a matching grant. If a slot's in-service bit is stuck or clears too early, the next `ack_o` rises a cycle or more ahead of the handshake, or never rises at all. A wrong end-of-row test inverts `spurious_o` one cycle after the window closes. The bench keeps its own cycle model of the window, the winner and the service bits, and it compares every output on every cycle, so any of these faults is caught on the cycle it first appears.

// File: rtl/irq_chain_pkg.sv
package irq_chain_pkg;

  typedef enum logic [1:0] {
    ARB_IDLE = 2'd0,
    ARB_ACK  = 2'd1,
    ARB_WAIT = 2'd2
  } arb_state_t;

  // width of a counter that must reach n-1
  function automatic int unsigned cnt_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

  // true on the final cycle of an acknowledge window
  function automatic logic win_last(input int unsigned cnt, input int unsigned win);
    return cnt == (win - 1);
  endfunction

endpackage

// File: rtl/irq_slot_cell.sv
module irq_slot_cell #(
  parameter int unsigned VEC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_i,
  input  logic [VEC_W-1:0] vec_i,
  input  logic             ack_in,
  output logic             ack_out,
  output logic             granted_o,
  output logic             in_service_o,
  output logic [VEC_W-1:0] vec_drive_o
);

  logic ack_prev_q;
  logic take_q;
  logic svc_q;
  logic ack_rise;
  logic take_now;

  // named internal events
  assign ack_rise = ack_in & ~ack_prev_q;
  assign take_now = ack_rise ? req_i : take_q;

  assign ack_out      = ack_in & ~take_now;
  assign granted_o    = ack_in & take_now;
  assign in_service_o = svc_q;
  assign vec_drive_o  = granted_o ? vec_i : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_prev_q <= 1'b0;
      take_q     <= 1'b0;
      svc_q      <= 1'b0;
    end else begin
      ack_prev_q <= ack_in;
      take_q     <= ack_in ? take_now : 1'b0;
      if (granted_o)   svc_q <= 1'b1;
      else if (!req_i) svc_q <= 1'b0;
    end
  end

  // R3: a granted slot keeps the acknowledge from the rest of the chain
  p_absorb_r3: assert property (@(posedge clk) disable iff (!rst_n)
    granted_o |-> !ack_out);

  // R4: the grant does not change inside one acknowledge window
  p_grant_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_in && $past(ack_in)) |-> $stable(granted_o));

  // R6: a slot enters service only through a grant
  p_svc_entry_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_service_o) |-> $past(granted_o));

endmodule

// File: rtl/irq_ack_arb.sv
module irq_ack_arb
  import irq_chain_pkg::*;
#(
  parameter int unsigned ACK_WIN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic irq_line,
  input  logic cpu_ready,
  input  logic ack_tail,
  input  logic any_in_service,
  output logic ack_o,
  output logic spurious_o
);

  localparam int unsigned CW = cnt_width(ACK_WIN);

  arb_state_t    state_q;
  logic [CW-1:0] cnt_q;
  logic          spur_q;
  logic          start_ack;
  logic          last_cyc;

  assign start_ack  = (state_q == ARB_IDLE) && irq_line && cpu_ready;
  assign last_cyc   = (state_q == ARB_ACK) && win_last(int'(cnt_q), ACK_WIN);
  assign ack_o      = (state_q == ARB_ACK);
  assign spurious_o = spur_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ARB_IDLE;
      cnt_q   <= '0;
      spur_q  <= 1'b0;
    end else begin
      unique case (state_q)
        ARB_IDLE: if (start_ack) begin
          state_q <= ARB_ACK;
          cnt_q   <= '0;
          spur_q  <= 1'b0;
        end
        ARB_ACK: if (last_cyc) begin
          spur_q  <= ack_tail;
          state_q <= ack_tail ? ARB_IDLE : ARB_WAIT;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
        ARB_WAIT: if (!any_in_service) state_q <= ARB_IDLE;
        default: state_q <= ARB_IDLE;
      endcase
    end
  end

  // R2: acknowledge starts only after request and readiness were seen
  p_ack_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_o) |-> $past(irq_line && cpu_ready));

  // R2: acknowledge ends only on the last counted cycle
  p_ack_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ack_o) |-> $past(last_cyc));

  // R6: no new acknowledge while a slot is still in service
  p_wait_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ARB_WAIT && any_in_service) |=> !ack_o);

  // R7: the flag rises only after a window that reached the chain end
  p_spur_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spurious_o) |-> $past(ack_o && ack_tail));

endmodule

// File: rtl/irq_daisy_chain.sv
module irq_daisy_chain
  import irq_chain_pkg::*;
#(
  parameter int unsigned SLOTS   = 4,
  parameter int unsigned VEC_W   = 8,
  parameter int unsigned ACK_WIN = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cpu_ready_i,
  input  logic [SLOTS-1:0]       req_i,
  input  logic [SLOTS*VEC_W-1:0] slot_vec_i,
  output logic                   irq_o,
  output logic                   ack_o,
  output logic [SLOTS-1:0]       grant_o,
  output logic [VEC_W-1:0]       vec_o,
  output logic                   vec_valid_o,
  output logic                   spurious_o
);

  logic [SLOTS:0]     ack_chain;
  logic [SLOTS-1:0]   svc;
  logic [VEC_W-1:0]   vec_part [SLOTS];
  logic               ack_tail;
  logic               any_in_service;

  // wired-OR request line
  assign irq_o          = |req_i;
  assign any_in_service = |svc;
  assign ack_chain[0]   = ack_o;
  assign ack_tail       = ack_chain[SLOTS];

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    irq_slot_cell #(.VEC_W(VEC_W)) u_cell (
      .clk          (clk),
      .rst_n        (rst_n),
      .req_i        (req_i[g]),
      .vec_i        (slot_vec_i[g*VEC_W +: VEC_W]),
      .ack_in       (ack_chain[g]),
      .ack_out      (ack_chain[g+1]),
      .granted_o    (grant_o[g]),
      .in_service_o (svc[g]),
      .vec_drive_o  (vec_part[g])
    );
  end

  // shared vector bus: undriven slots contribute zero
  always_comb begin
    vec_o = '0;
    for (int i = 0; i < SLOTS; i++) vec_o = vec_o | vec_part[i];
  end
  assign vec_valid_o = |grant_o;

  irq_ack_arb #(.ACK_WIN(ACK_WIN)) u_arb (
    .clk            (clk),
    .rst_n          (rst_n),
    .irq_line       (irq_o),
    .cpu_ready      (cpu_ready_i),
    .ack_tail       (ack_tail),
    .any_in_service (any_in_service),
    .ack_o          (ack_o),
    .spurious_o     (spurious_o)
  );

  // R4: never more than one grant
  p_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_o));

  // R5: a valid vector needs an acknowledge in flight
  p_vec_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid_o |-> ack_o);

  // R3: a grant implies the acknowledge did not reach the chain end
  p_grant_tail_r3: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid_o |-> !ack_tail);

endmodule

// File: tb/irq_daisy_chain_tb.sv
module irq_daisy_chain_tb;

  localparam int K  = 4;
  localparam int VW = 8;
  localparam int W  = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ready = 1'b0;
  logic [K-1:0]  req = '0;
  logic [K*VW-1:0] vecs;
  logic          irq, ack, vvalid, spur;
  logic [K-1:0]  grant;
  logic [VW-1:0] vec;

  int n_chk = 0;
  int n_fail = 0;
  bit run_cmp = 1'b0;

  always #4 clk = ~clk;

  irq_daisy_chain #(.SLOTS(K), .VEC_W(VW), .ACK_WIN(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .cpu_ready_i(ready), .req_i(req),
    .slot_vec_i(vecs), .irq_o(irq), .ack_o(ack), .grant_o(grant),
    .vec_o(vec), .vec_valid_o(vvalid), .spurious_o(spur));

  // slot i vector: distinct constant per slot
  initial for (int i = 0; i < K; i++) vecs[i*VW +: VW] = 8'h30 + 8'(i * 17);

  // ---------------- reference model ----------------
  int m_state = 0;            // 0 idle, 1 window, 2 wait
  int m_cnt = 0;
  int m_win = K;
  bit m_spur = 0;
  bit [K-1:0] m_svc = '0;

  function automatic int first_req(input logic [K-1:0] r);
    for (int i = 0; i < K; i++) if (r[i]) return i;
    return K;
  endfunction

  function automatic int cur_win();
    return (m_cnt == 0) ? first_req(req) : m_win;
  endfunction

  function automatic logic [K-1:0] exp_grant();
    int w = cur_win();
    if (m_state != 1 || w >= K) return '0;
    return K'(1) << w;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_state <= 0; m_cnt <= 0; m_win <= K; m_spur <= 0; m_svc <= '0;
    end else begin
      logic [K-1:0] g;
      int w;
      g = exp_grant();
      for (int i = 0; i < K; i++) begin
        if (g[i]) m_svc[i] <= 1'b1;
        else if (!req[i]) m_svc[i] <= 1'b0;
      end
      case (m_state)
        0: if ((|req) && ready) begin m_state <= 1; m_cnt <= 0; m_spur <= 0; end
        1: begin
          w = cur_win();
          m_win <= w;
          if (m_cnt == W - 1) begin
            m_spur  <= (w >= K);
            m_state <= (w >= K) ? 0 : 2;
          end else m_cnt <= m_cnt + 1;
        end
        default: if (m_svc == '0) m_state <= 0;
      endcase
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] ex);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, ex, $time);
    end
  endtask

  always @(negedge clk) if (run_cmp && rst_n) begin
    logic [K-1:0] eg;
    logic [VW-1:0] ev;
    eg = exp_grant();
    ev = '0;
    for (int i = 0; i < K; i++) if (eg[i]) ev = vecs[i*VW +: VW];
    chk(irq == (|req), "R1 irq", 32'(irq), 32'(|req));
    chk(ack == (m_state == 1), "R2/R6 ack", 32'(ack), 32'(m_state == 1));
    chk(grant == eg, "R3/R4 grant", 32'(grant), 32'(eg));
    chk(vec == ev && vvalid == (|eg), "R5 vector", {vvalid, vec}, {|eg, ev});
    chk(spur == m_spur, "R7 spurious", 32'(spur), 32'(m_spur));
  end

  task automatic step(input logic [K-1:0] r, input logic rd);
    @(posedge clk); #1; req = r; ready = rd;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
  endtask

  initial begin
    #2000000;
    n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    idle(2);
    @(negedge clk);
    chk(ack == 0 && grant == 0 && vec == 0 && !vvalid && !spur, "R8 reset state",
        {ack, grant, vec, vvalid, spur}, 32'h0);
    #1 rst_n = 1'b1;
    run_cmp = 1'b1;

    // R3: slots 1 and 3 together, slot 1 wins, then handler clears it (R6)
    step(4'b1010, 1'b1);
    step(4'b1010, 1'b1);
    @(negedge clk); chk(grant == 4'b0010, "R3 priority slot1", 32'(grant), 32'h2);
    chk(vec == 8'h41, "R5 vector slot1", 32'(vec), 32'h41);
    // R4: slot 0 raises mid window, must not steal
    step(4'b1011, 1'b1);
    @(negedge clk); chk(grant == 4'b0010, "R4 no steal", 32'(grant), 32'h2);
    idle(4);
    @(negedge clk); chk(ack == 0, "R6 wait for clear", 32'(ack), 32'h0);
    step(4'b1001, 1'b1);
    idle(6);
    step(4'b0000, 1'b0);
    idle(8);
    // R7: request vanishes before the window opens
    step(4'b0100, 1'b1);
    step(4'b0000, 1'b1);
    idle(W + 1);
    @(negedge clk); chk(spur == 1'b1, "R7 spurious set", 32'(spur), 32'h1);
    // R1: two requests, single line
    step(4'b0110, 1'b0);
    @(negedge clk); chk(irq == 1'b1, "R1 wired OR", 32'(irq), 32'h1);
    step(4'b0000, 1'b0);
    idle(2);

    // random phase
    for (int c = 0; c < 3000; c++) begin
      logic [K-1:0] r;
      r = req;
      for (int i = 0; i < K; i++) if (($urandom % 8) == 0) r[i] = ~r[i];
      step(r, ($urandom % 4) != 0);
    end
    step('0, 1'b0);
    idle(12);
    run_cmp = 1'b0;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule